// File: doc/BRIEF.md
# Serial Configuration Port with Chip-Select Wake

This block is the write-only control port of a mixed-signal front end. A host drives three wires (an active-low select, a serial clock and a data line). The block shifts in 16-bit command words and writes them into a small set of configuration registers. It also holds the power-mode register. All three serial wires are brought into the system clock domain through two-flop synchronisers. Edges of the serial clock are found by comparing samples, so the system clock has to run several times faster than the serial clock.

Each frame carries a 4-bit register address in its upper bits and a 12-bit value in its lower bits. The frame is committed only when select returns high after exactly 16 serial clock rising edges. A frame that begins too soon after the previous one is discarded. In shutdown the port ignores the data of a frame and treats the select pulse as a wake request: the power mode becomes the stored wake target, and every other setting keeps its value. Each accepted write or wake raises a one-cycle strobe, which downstream logic can use to start a mode-recovery timer.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame starts when `sel_n` falls. `sdi` is sampled on each rising edge of `sck`, most significant bit first. After exactly 16 rising edges, the rise of `sel_n` commits the word: bits [15:12] select the register and bits [11:0] are the value. Registers update a few system clocks after `sel_n` rises and never during the frame.
- R2: The port works the same whether `sck` rests low or rests high between frames.
- R3: A frame that ends after any number of rising `sck` edges other than 16 changes no register.
- R4: A frame is discarded entirely if `sel_n` was high for fewer than `MIN_GAP_CLKS` system clocks before it fell. This also applies to a wake pulse.
- R5: Address map: 1 is the power mode, 2 is the wake target, 3 is `offset_q`, 4 is `cmode_q`, 5 is `aux_dac_q` and 6 is `aux_ctl_q`. A frame to any other address changes nothing. The two mode registers take their value from bits [2:0] of the data field.
- R6: Power-mode codes are 0 shutdown, 1 idle, 2 standby, 3 receive, 4 transmit and 5 full duplex. A write of 6 or 7 to address 1 is ignored.
- R7: The wake target accepts only codes 1 to 5. A write of 0 (the shutdown code), 6 or 7 leaves it at its previous value.
- R8: While the power mode is shutdown, a select pulse sets the power mode to the wake target. The data shifted during that pulse is ignored, and no other register changes.
- R9: `commit` is high for exactly one cycle for each accepted write or wake. It stays low for every rejected or discarded frame.
- R10: After reset, the power mode is idle (1), the wake target is full duplex (5), the four settings are zero and `commit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| power_mode | output | 3 | Current power mode |
| wake_sel | output | 3 | Mode entered when waking from shutdown |
| offset_q | output | 12 | Transmit offset setting |
| cmode_q | output | 12 | Transmit common-mode setting |
| aux_dac_q | output | 12 | Auxiliary DAC setting |
| aux_ctl_q | output | 12 | Auxiliary converter control |
| commit | output | 1 | One-cycle strobe on each accepted write or wake |

## Verification
The bench sends frames of 15 and 17 bits, because a design that commits whenever select rises would write garbage on them. It sends frames closely after a short select-high gap, which a port without the gap counter would accept. It enters shutdown and sends a wake pulse that carries a full register write: a design that decodes that word would change a setting instead of only restoring the mode. It also writes the reserved wake code and the modes 6 and 7, and repeats frames with `sck` resting high. A port that keyed on the clock level would gain or lose a bit there, and a design that let an illegal code through would show a mode outside the legal set.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int FRAME_BITS   = 16,
  parameter int ADDR_BITS    = 4,
  parameter int MODE_BITS    = 3,
  parameter int MIN_GAP_CLKS = 20
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sel_n,
  input  logic                                sck,
  input  logic                                sdi,
  output logic [MODE_BITS-1:0]                power_mode,
  output logic [MODE_BITS-1:0]                wake_sel,
  output logic [FRAME_BITS-ADDR_BITS-1:0]     offset_q,
  output logic [FRAME_BITS-ADDR_BITS-1:0]     cmode_q,
  output logic [FRAME_BITS-ADDR_BITS-1:0]     aux_dac_q,
  output logic [FRAME_BITS-ADDR_BITS-1:0]     aux_ctl_q,
  output logic                                commit
);
  localparam int DATA_BITS = FRAME_BITS - ADDR_BITS;
  localparam int CNT_W     = $clog2(FRAME_BITS + 2);
  localparam int GAP_W     = $clog2(MIN_GAP_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [GAP_W-1:0] GAP_MIN  = GAP_W'(MIN_GAP_CLKS);

  localparam logic [MODE_BITS-1:0] M_SHUT = MODE_BITS'(0);
  localparam logic [MODE_BITS-1:0] M_IDLE = MODE_BITS'(1);
  localparam logic [MODE_BITS-1:0] M_FD   = MODE_BITS'(5);

  localparam logic [ADDR_BITS-1:0] A_MODE = ADDR_BITS'(1);
  localparam logic [ADDR_BITS-1:0] A_WAKE = ADDR_BITS'(2);
  localparam logic [ADDR_BITS-1:0] A_OFFS = ADDR_BITS'(3);
  localparam logic [ADDR_BITS-1:0] A_CMOD = ADDR_BITS'(4);
  localparam logic [ADDR_BITS-1:0] A_ADAC = ADDR_BITS'(5);
  localparam logic [ADDR_BITS-1:0] A_ACTL = ADDR_BITS'(6);

  logic [2:0] cs_sr, sck_sr;
  logic [1:0] sdi_sr;
  logic       active, gap_ok;
  logic [CNT_W-1:0]      bit_cnt;
  logic [GAP_W-1:0]      gap_cnt;
  logic [FRAME_BITS-1:0] shreg;

  wire cs_s     = cs_sr[1];
  wire cs_fall  = cs_sr[2] & ~cs_sr[1];
  wire cs_rise  = ~cs_sr[2] & cs_sr[1];
  wire sck_rise = sck_sr[1] & ~sck_sr[2];

  wire [ADDR_BITS-1:0] f_addr = shreg[FRAME_BITS-1:DATA_BITS];
  wire [DATA_BITS-1:0] f_data = shreg[DATA_BITS-1:0];
  wire [MODE_BITS-1:0] f_mode = shreg[MODE_BITS-1:0];
  wire mode_ok = (f_mode <= M_FD);
  wire wake_ok = mode_ok && (f_mode != M_SHUT);
  wire frame_end = cs_rise && active && gap_ok;
  wire full_frame = (bit_cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr  <= '1;
      sck_sr <= '0;
      sdi_sr <= '0;
    end else begin
      cs_sr  <= {cs_sr[1:0], sel_n};
      sck_sr <= {sck_sr[1:0], sck};
      sdi_sr <= {sdi_sr[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= GAP_MIN;
      active  <= 1'b0;
      gap_ok  <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      if (!cs_s)
        gap_cnt <= '0;
      else if (gap_cnt < GAP_MIN)
        gap_cnt <= gap_cnt + 1'b1;

      if (cs_fall) begin
        active  <= 1'b1;
        gap_ok  <= (gap_cnt >= GAP_MIN);
        bit_cnt <= '0;
      end else if (active && !cs_s && sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], sdi_sr[1]};
        if (bit_cnt != CNT_SAT)
          bit_cnt <= bit_cnt + 1'b1;
      end else if (cs_rise) begin
        active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_mode <= M_IDLE;
      wake_sel   <= M_FD;
      offset_q   <= '0;
      cmode_q    <= '0;
      aux_dac_q  <= '0;
      aux_ctl_q  <= '0;
      commit     <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (frame_end) begin
        if (power_mode == M_SHUT) begin
          power_mode <= wake_sel;
          commit     <= 1'b1;
        end else if (full_frame) begin
          case (f_addr)
            A_MODE: if (mode_ok) begin power_mode <= f_mode; commit <= 1'b1; end
            A_WAKE: if (wake_ok) begin wake_sel <= f_mode; commit <= 1'b1; end
            A_OFFS: begin offset_q  <= f_data; commit <= 1'b1; end
            A_CMOD: begin cmode_q   <= f_data; commit <= 1'b1; end
            A_ADAC: begin aux_dac_q <= f_data; commit <= 1'b1; end
            A_ACTL: begin aux_ctl_q <= f_data; commit <= 1'b1; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int MW = 3,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW-1:0] power_mode,
  input logic [MW-1:0] wake_sel,
  input logic [DW-1:0] offset_q,
  input logic [DW-1:0] cmode_q,
  input logic [DW-1:0] aux_dac_q,
  input logic [DW-1:0] aux_ctl_q,
  input logic          commit
);
  localparam logic [MW-1:0] SHUT = MW'(0);
  localparam logic [MW-1:0] TOP  = MW'(5);

  assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    power_mode <= TOP);

  assert_wake_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sel != SHUT) && (wake_sel <= TOP));

  assert_wake_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(power_mode) == SHUT && power_mode != SHUT) |-> power_mode == $past(wake_sel));

  assert_hold_in_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(power_mode) == SHUT) |-> ($stable(offset_q) && $stable(cmode_q) &&
      $stable(aux_dac_q) && $stable(aux_ctl_q) && $stable(wake_sel)));

  assert_commit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  assert_change_has_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(power_mode) || !$stable(wake_sel) || !$stable(offset_q) ||
     !$stable(cmode_q) || !$stable(aux_dac_q) || !$stable(aux_ctl_q)) |-> commit);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.MW(MODE_BITS), .DW(FRAME_BITS - ADDR_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .power_mode(power_mode), .wake_sel(wake_sel),
  .offset_q(offset_q), .cmode_q(cmode_q), .aux_dac_q(aux_dac_q),
  .aux_ctl_q(aux_ctl_q), .commit(commit));

// File: tb/cfg_serial_port_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_port_tb_top;
  logic clk = 0, rst_n = 0, sel_n = 1, sck = 0, sdi = 0;
  logic [2:0] power_mode, wake_sel;
  logic [11:0] offset_q, cmode_q, aux_dac_q, aux_ctl_q;
  logic commit;

  always #2 clk = ~clk;

  cfg_serial_port #(.MIN_GAP_CLKS(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .power_mode(power_mode), .wake_sel(wake_sel), .offset_q(offset_q),
    .cmode_q(cmode_q), .aux_dac_q(aux_dac_q), .aux_ctl_q(aux_ctl_q),
    .commit(commit));

  int checks = 0, failures = 0, seen_commits = 0;
  int m_mode = 1, m_wsel = 5, m_off = 0, m_cm = 0, m_ad = 0, m_ac = 0, m_commits = 0;
  bit last_gap_ok = 1;

  always @(negedge clk) if (rst_n && commit) seen_commits++;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    chk(tag, "power_mode", int'(power_mode), m_mode);
    chk(tag, "wake_sel",   int'(wake_sel),   m_wsel);
    chk(tag, "offset_q",   int'(offset_q),   m_off);
    chk(tag, "cmode_q",    int'(cmode_q),    m_cm);
    chk(tag, "aux_dac_q",  int'(aux_dac_q),  m_ad);
    chk(tag, "aux_ctl_q",  int'(aux_ctl_q),  m_ac);
    chk(tag, "commit count (R9)", seen_commits, m_commits);
  endtask

  function automatic void model(input logic [15:0] w, input int n);
    int a = int'(w[15:12]);
    int d = int'(w[11:0]);
    int md = d & 7;
    if (!last_gap_ok) return;
    if (m_mode == 0) begin m_mode = m_wsel; m_commits++; return; end
    if (n != 16) return;
    case (a)
      1: if (md <= 5) begin m_mode = md; m_commits++; end
      2: if (md >= 1 && md <= 5) begin m_wsel = md; m_commits++; end
      3: begin m_off = d; m_commits++; end
      4: begin m_cm  = d; m_commits++; end
      5: begin m_ad  = d; m_commits++; end
      6: begin m_ac  = d; m_commits++; end
      default: ;
    endcase
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int n, input bit idle_hi, input int gap);
    sck = idle_hi;
    wclk(4);
    sel_n = 0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      if (idle_hi) sck = 0;
      sdi = (i < 16) ? w[15-i] : 1'($urandom);
      wclk(4);
      sck = 1;
      wclk(4);
      if (!idle_hi) sck = 0;
    end
    wclk(4);
    sel_n = 1;
    wclk(gap);
    model(w, n);
    last_gap_ok = (gap + 4 >= 20);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    wclk(5);
    rst_n = 1;
    wclk(2);
    check_all("R10 reset");
    chk("R10", "commit low", int'(commit), 0);

    send(16'h3ABC, 16, 0, 25); check_all("R1 offset write");
    send(16'h45A5, 16, 1, 25); check_all("R2 idle-high cmode write");
    send(16'h5777, 15, 0, 25); check_all("R3 15-bit frame");
    send(16'h5777, 17, 1, 25); check_all("R3 17-bit frame");
    send(16'h6111, 16, 0, 6);  check_all("R4 write before short gap");
    send(16'h5222, 16, 0, 25); check_all("R4 frame after short gap");
    send(16'h5333, 16, 1, 25); check_all("R4 frame after long gap");
    send(16'h9FFF, 16, 0, 25); check_all("R5 unknown address");
    send(16'h1007, 16, 0, 25); check_all("R6 mode 7 rejected");
    send(16'h1006, 16, 1, 25); check_all("R6 mode 6 rejected");
    send(16'h1004, 16, 0, 25); check_all("R6 mode 4 accepted");
    send(16'h2000, 16, 0, 25); check_all("R7 wake code 0 rejected");
    send(16'h2003, 16, 1, 25); check_all("R7 wake code 3 accepted");
    send(16'h1000, 16, 0, 25); check_all("R6 enter shutdown");
    send(16'h3FFF, 16, 0, 25); check_all("R8 wake ignores data");
    chk("R8", "mode after wake", int'(power_mode), 3);
    send(16'h1000, 16, 1, 25);
    send(16'h2005, 9, 0, 25);  check_all("R8 short wake pulse");

    for (int k = 0; k < 200; k++) begin
      int sel = int'($urandom_range(0, 9));
      logic [3:0] a = (sel < 7) ? 4'(sel) : ((sel == 7) ? 4'd1 : 4'(8 + $urandom_range(0, 7)));
      logic [11:0] d = 12'($urandom);
      int n = ($urandom_range(0, 9) == 0) ? int'($urandom_range(8, 18)) : 16;
      int g = ($urandom_range(0, 9) == 0) ? 8 : 25;
      if (sel == 7) d[2:0] = 3'd0;
      send({a, d}, n, 1'($urandom), g);
      check_all("R1 R9 random frame");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule